// File: doc/BRIEF.md
# Infrared pulse run-length encoder

This block watches the one-bit output of an infrared receiver and converts the waveform into a stream of run-length bytes. The line is sampled once every 64 base clocks. An optional inversion is applied first, so receivers that idle at either level can be used. Each stretch of constant level becomes one byte. The top bit of the byte is the level, and the low seven bits are the stretch length in samples minus one.

Short disturbances are absorbed into the surrounding run. A run that is too long for seven bits is split into full-length bytes. When the line stays in the non-pulse level for a programmable number of 128-sample blocks, the block closes the packet. It emits the last partial run and then pulses a packet-end flag. Between packets the line is idle and nothing is emitted. The byte strobe and the packet-end flag feed a downstream queue, which is not part of this block.

Top module: `ir_rle`

## Requirements
- R1: The encoder runs only while `glob_en` and `rx_en` are both 1 and `mode` equals 2'b11. In any other case all run state and the sample divider are cleared, and `byte_valid` and `pkt_end` stay 0.
- R2: A sample is taken at the clock edge that ends each group of 64 active clocks, counted from the start of activation. A byte produced by a sample shows `byte_valid` high for exactly the following clock cycle.
- R3: The sampled level is `ir_in` XOR `invert`. Level 1 is a pulse and level 0 is a space.
- R4: A byte is `{level, length-1}`, with the level in bit 7 and the length in samples in bits 6:0. A run's byte is emitted at the sample that confirms the next run.
- R5: An opposite-level stretch of at most `noise_thr` samples is merged into the current run, and all of its samples are added to that run's length. The sample numbered `noise_thr`+1 of an opposite stretch confirms it as a new run, with the length it has at that point. With `noise_thr`=0, every level change is a new run.
- R6: When a run's length would reach 129 samples, a byte with length field 127 is emitted and counting continues for the same level with the remainder.
- R7: A packet starts only when a pulse is confirmed under R5. The space before a packet is never emitted, and no byte or packet end occurs while the line idles between packets.
- R8: A space run inside a packet ends the packet when its committed length reaches `idle_thr`×128 samples, with 0 treated as 1. The remaining partial run is emitted as a byte, with its length field capped at 127. `pkt_end` pulses for one clock on the cycle right after that byte, and the encoder returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| mode | input | 2 | Operating mode; 2'b11 selects run-length receive |
| invert | input | 1 | Invert the input line before sampling |
| noise_thr | input | 6 | Maximum merged disturbance length, in samples |
| idle_thr | input | 8 | Packet-end space length, in units of 128 samples |
| ir_in | input | 1 | Raw receiver line |
| byte_valid | output | 1 | One-clock strobe for `byte_data` |
| byte_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | One-clock packet-end pulse |

## Verification
Two situations are the hardest to reach from the ports. The first is a disturbance inside a run that must land in that run's length. The second is a space that crosses a 128-sample split before it reaches the idle limit, so that the split byte and the flush byte follow each other. The stimulus holds the line for whole multiples of 64 clocks. It places glitches exactly one sample and exactly `noise_thr` samples long between longer runs. It also drives spaces of 300 samples with a two-block idle limit, so both closing bytes appear. A reference model in the bench follows every clock, so an early or late strobe is caught even when the byte values are right.

// File: rtl/ir_rle.sv
`timescale 1ns/1ps
module ir_rle #(
  parameter int DIV = 64,
  parameter int NTHR_W = 6,
  parameter int ITHR_W = 8,
  parameter int LEN_W = 7,
  parameter logic [1:0] RLE_MODE = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic              rx_en,
  input  logic [1:0]        mode,
  input  logic              invert,
  input  logic [NTHR_W-1:0] noise_thr,
  input  logic [ITHR_W-1:0] idle_thr,
  input  logic              ir_in,
  output logic              byte_valid,
  output logic [LEN_W:0]    byte_data,
  output logic              pkt_end
);
  localparam int PC_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int RUN_W = LEN_W + 1;
  localparam int PD_W = NTHR_W + 1;
  localparam int SUM_W = ((RUN_W > PD_W) ? RUN_W : PD_W) + 1;
  localparam int TOT_W = ITHR_W + LEN_W + 1;
  localparam int RUN_MAX = 1 << LEN_W;

  logic [PC_W-1:0]  pc;
  logic             lvl, busy, flush_q;
  logic [RUN_W-1:0] len;
  logic [PD_W-1:0]  pend;
  logic [TOT_W-1:0] tot;

  wire              active   = glob_en && rx_en && (mode == RLE_MODE);
  wire              tick     = active && (pc == PC_W'(DIV - 1));
  wire              smp      = ir_in ^ invert;
  wire [PD_W-1:0]   pend_inc = pend + 1'b1;
  wire              confirm  = pend_inc > PD_W'(noise_thr);
  wire [SUM_W-1:0]  sum      = SUM_W'(len) + SUM_W'(pend_inc);
  wire              over     = sum > SUM_W'(RUN_MAX);
  wire [TOT_W-1:0]  tot_nx   = tot + TOT_W'(pend_inc);
  wire [ITHR_W-1:0] ithr     = (idle_thr == '0) ? ITHR_W'(1) : idle_thr;
  wire              idle_hit = tot_nx >= (TOT_W'(ithr) << LEN_W);
  wire [LEN_W-1:0]  len_m1   = LEN_W'(len - 1'b1);
  wire [LEN_W-1:0]  sum_m1   = over ? {LEN_W{1'b1}} : LEN_W'(sum - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; lvl <= 1'b0; busy <= 1'b0; len <= '0; pend <= '0; tot <= '0;
      flush_q <= 1'b0; byte_valid <= 1'b0; byte_data <= '0; pkt_end <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      flush_q    <= 1'b0;
      pkt_end    <= flush_q;
      if (!active) begin
        pc <= '0; lvl <= 1'b0; busy <= 1'b0; len <= '0; pend <= '0; tot <= '0;
        pkt_end <= 1'b0;
      end else begin
        pc <= tick ? '0 : pc + 1'b1;
        if (tick) begin
          if (!busy) begin
            if (!smp) pend <= '0;
            else if (confirm) begin
              busy <= 1'b1; lvl <= 1'b1; len <= RUN_W'(pend_inc); pend <= '0; tot <= '0;
            end else pend <= pend_inc;
          end else if (smp == lvl) begin
            pend <= '0;
            if (!lvl && idle_hit) begin
              byte_valid <= 1'b1; byte_data <= {1'b0, sum_m1};
              flush_q <= 1'b1; busy <= 1'b0; len <= '0; tot <= '0;
            end else begin
              tot <= tot_nx;
              if (over) begin
                byte_valid <= 1'b1; byte_data <= {lvl, {LEN_W{1'b1}}};
                len <= RUN_W'(sum - SUM_W'(RUN_MAX));
              end else len <= RUN_W'(sum);
            end
          end else if (confirm) begin
            byte_valid <= 1'b1; byte_data <= {lvl, len_m1};
            lvl <= smp; len <= RUN_W'(pend_inc); pend <= '0; tot <= TOT_W'(pend_inc);
          end else pend <= pend_inc;
        end
      end
    end
  end
endmodule

// File: rtl/ir_rle_chk.sv
`timescale 1ns/1ps
module ir_rle_chk (
  input logic clk,
  input logic rst_n,
  input logic act,
  input logic byte_valid,
  input logic msb,
  input logic pkt_end
);
  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!byte_valid && !pkt_end));
  assert_strobe_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  assert_flush_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> ($past(byte_valid) && !$past(msb)));
  assert_end_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end);
  assert_end_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> !byte_valid);
endmodule

bind ir_rle ir_rle_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .act(glob_en && rx_en && (mode == RLE_MODE)),
  .byte_valid(byte_valid), .msb(byte_data[LEN_W]), .pkt_end(pkt_end)
);

// File: tb/sim_ir_rle.sv
`timescale 1ns/1ps
module sim_ir_rle;
  logic clk = 0, rst_n = 0, glob_en = 0, rx_en = 0, invert = 0, ir_in = 0;
  logic [1:0] mode = 2'b00;
  logic [5:0] noise_thr = 6'd1;
  logic [7:0] idle_thr = 8'd2;
  logic byte_valid, pkt_end;
  logic [7:0] byte_data;

  always #10 clk = ~clk;

  ir_rle u0 (.clk(clk), .rst_n(rst_n), .glob_en(glob_en), .rx_en(rx_en), .mode(mode),
             .invert(invert), .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_in(ir_in),
             .byte_valid(byte_valid), .byte_data(byte_data), .pkt_end(pkt_end));

  int vectors = 0, errors = 0, cyc = 0, npe = 0;
  string req = "R1";
  logic [7:0] got[$];

  int m_pc = 0, m_lvl = 0, m_len = 0, m_pend = 0, m_tot = 0, m_busy = 0, m_flush = 0;
  bit e_v = 0, e_pe = 0;
  logic [7:0] e_d = 0;

  function automatic void em(int l, int n);
    e_v = 1;
    e_d = {l[0], n[6:0]};
  endfunction

  always @(posedge clk) begin : model
    int s, sum, lim;
    e_pe = m_flush[0]; m_flush = 0; e_v = 0;
    if (!rst_n || !(glob_en && rx_en && mode == 2'b11)) begin
      m_pc = 0; m_lvl = 0; m_len = 0; m_pend = 0; m_tot = 0; m_busy = 0; e_pe = 0;
    end else if (m_pc != 63) m_pc++;
    else begin
      m_pc = 0;
      s = ir_in ^ invert;
      lim = ((idle_thr == 0) ? 1 : int'(idle_thr)) * 128;
      if (!m_busy) begin
        if (s == 1) begin
          m_pend++;
          if (m_pend > noise_thr) begin m_busy = 1; m_lvl = 1; m_len = m_pend; m_pend = 0; m_tot = 0; end
        end else m_pend = 0;
      end else if (s == m_lvl) begin
        sum = m_len + m_pend + 1;
        m_tot = m_tot + m_pend + 1;
        m_pend = 0;
        if (m_lvl == 0 && m_tot >= lim) begin
          em(0, ((sum > 128) ? 128 : sum) - 1);
          m_flush = 1; m_busy = 0; m_len = 0; m_tot = 0;
        end else if (sum > 128) begin em(m_lvl, 127); m_len = sum - 128; end
        else m_len = sum;
      end else begin
        m_pend++;
        if (m_pend > noise_thr) begin
          em(m_lvl, m_len - 1);
          m_lvl = s; m_len = m_pend; m_tot = m_pend; m_pend = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    vectors++;
    if (byte_valid !== e_v || pkt_end !== e_pe || (e_v && byte_data !== e_d)) begin
      errors++;
      $display("FAIL %s cycle %0d: actual v=%b d=%h end=%b expected v=%b d=%h end=%b",
               req, cyc, byte_valid, byte_data, pkt_end, e_v, e_d, e_pe);
    end
    if (byte_valid === 1'b1) got.push_back(byte_data);
    if (pkt_end === 1'b1) npe++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic send(input int lv, input int n);
    ir_in = lv[0] ^ invert;
    repeat (n * 64) @(negedge clk);
  endtask

  task automatic chk(input string r, input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic chkq(input string r, input logic [7:0] ex[$], input int pe_exp);
    chk(r, got.size() == ex.size(), "byte count", got.size(), ex.size());
    for (int i = 0; i < ex.size() && i < got.size(); i++)
      chk(r, got[i] == ex[i], $sformatf("byte %0d", i), got[i], ex[i]);
    chk(r, npe == pe_exp, "packet ends", npe, pe_exp);
    got.delete();
    npe = 0;
  endtask

  initial begin
    @(negedge clk);
    chk("R1", byte_valid === 1'b0 && pkt_end === 1'b0, "reset outputs", byte_valid, 0);
    rst_n = 1;
    // R1: wrong mode, then receive disabled: nothing emitted
    req = "R1"; glob_en = 1; rx_en = 1; mode = 2'b01;
    for (int i = 0; i < 2; i++) begin send(1, 10); send(0, 10); end
    mode = 2'b11; rx_en = 0;
    for (int i = 0; i < 2; i++) begin send(1, 10); send(0, 10); end
    chkq("R1", '{}, 0);
    // R4/R5/R6/R8: format, one-sample glitch merged, split then idle flush
    req = "R4"; rx_en = 1; noise_thr = 1; idle_thr = 2;
    send(0, 5); send(1, 10); send(0, 6); send(1, 3); send(0, 1); send(1, 4); send(0, 300);
    chkq("R4", '{8'h89, 8'h05, 8'h87, 8'h7F, 8'h7F}, 1);
    // R7 idle gap silent, R6 long pulse split
    req = "R6"; idle_thr = 1;
    send(0, 20);
    chk("R7", got.size() == 0, "bytes while idle", got.size(), 0);
    send(1, 300); send(0, 140);
    chkq("R6", '{8'hFF, 8'hFF, 8'hAB, 8'h7F}, 1);
    // R3: inverted input, zero noise threshold, idle_thr 0 acts as 1
    req = "R3"; invert = 1; noise_thr = 0; idle_thr = 0;
    send(0, 10); send(1, 5); send(0, 1); send(1, 1); send(0, 130);
    chkq("R3", '{8'h84, 8'h00, 8'h80, 8'h7F}, 1);
    // R5: stretch equal to threshold merged, threshold+1 confirms
    req = "R5"; invert = 0; noise_thr = 3; idle_thr = 1;
    send(1, 6); send(0, 3); send(1, 4); send(0, 4); send(1, 5); send(0, 130);
    chkq("R5", '{8'h8C, 8'h03, 8'h84, 8'h7F}, 1);
    // R2: disable mid-packet clears state, divider restarts on re-enable
    req = "R2"; noise_thr = 0;
    send(1, 5);
    rx_en = 0; repeat (10) @(negedge clk); rx_en = 1;
    send(0, 10); send(1, 3); send(0, 130);
    chkq("R2", '{8'h82, 8'h7F}, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule